// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the access address for a four-beat burst. When an external address strobe has been accepted (the decision is made outside), the block captures the full external address. That address becomes beat 0. On each later cycle with an advance request, the two low address bits move to the next beat. The upper bits stay as they were captured. When there is no advance request, the address is held and the burst is suspended.

A static order-select input picks one of two beat orders:
- Interleaved: the beat index is XORed into the starting low bits.
- Linear: the beat index is added to the starting low bits, wrapping modulo four.

An advance request on the same edge as a load has no effect. After the fourth beat the sequence wraps back to its first address and keeps looping.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is zero. After reset is released it stays zero until the first load.
- R2: On a rising edge where `load_i` is 1, `addr_o` takes the value of `ext_addr_i` from the next cycle onward. This address is beat 0.
- R3: With `order_sel_i` = 1 (interleaved), the low two bits of `addr_o` at beat n equal start XOR n. For example, start 01 gives 01, 00, 11, 10.
- R4: With `order_sel_i` = 0 (linear), the low two bits of `addr_o` at beat n equal (start + n) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: `adv_i` is ignored on an edge where `load_i` is 1. The loaded address appears as beat 0 either way.
- R6: On an edge where both `load_i` and `adv_i` are 0, `addr_o` keeps its value.
- R7: Bits above the low two of `addr_o` stay as loaded throughout the burst, including across a wrap.
- R8: An advance after the fourth beat returns the low bits to the starting value. The order repeats every four beats.
- R9: A load in the middle of a burst discards the old burst and starts the new address at beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_addr_i | input | ADDR_W | External address captured on load |
| load_i | input | 1 | Accepted address strobe; loads a new burst start |
| adv_i | input | 1 | Advance request; steps the burst when no load occurs |
| order_sel_i | input | 1 | Beat order: 1 interleaved, 0 linear (static) |
| addr_o | output | ADDR_W | Current access address |

## Verification
The bound checker watches every cycle for the following:
- A load places the external address on the output one cycle later, whatever the advance input does.
- An idle cycle leaves the address unchanged.
- A step never alters the upper bits.
- A linear step raises the low bits by exactly one, modulo four.
- An interleaved step always changes the low bits.

The full beat sequences can only be shown by the bench's scenarios, which walk bursts from several start offsets in both orders. These scenarios cover:
- the exact interleaved values;
- the wrap back to the first beat;
- a reload in the middle of a burst;
- a suspension in the middle of a burst;
- the reset value.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_start_reg.sv
// Captures the burst start address on an accepted strobe.
module burst_start_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] start_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_o <= '0;
    else if (load_i) start_o <= ext_addr_i;
  end

endmodule

// File: rtl/burst_beat_ctr.sv
// Beat index: cleared on load, stepped on advance; load wins over advance.
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (load_i) beat_o <= '0;
    else if (adv_i)  beat_o <= beat_o + 1'b1;
  end

endmodule

// File: rtl/burst_order_map.sv
// Maps start offset and beat index to the sequenced low bits.
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              order_sel_i,
  output logic [BEAT_W-1:0] lo_o
);

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  // interleaved: bitwise XOR per bit
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_lo[b] = start_lo_i[b] ^ beat_i[b];
  end

  assign lin_lo = start_lo_i + beat_i;  // wraps mod 2**BEAT_W

  always_comb begin
    if (burst_order_e'(order_sel_i) == ORD_INTERLEAVE) lo_o = ilv_lo;
    else                                               lo_o = lin_lo;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] lo_seq;

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .ext_addr_i (ext_addr_i),
    .start_o    (start_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_i  (adv_i),
    .beat_o (beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo_i  (start_q[BEAT_W-1:0]),
    .beat_i      (beat_q),
    .order_sel_i (order_sel_i),
    .lo_o        (lo_seq)
  );

  logic [UPPER_W-1:0] upper;
  assign upper  = start_q[ADDR_W-1:BEAT_W];
  assign addr_o = {upper, lo_seq};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic              load_i,
  input logic              adv_i,
  input logic              order_sel_i,
  input logic [ADDR_W-1:0] addr_o
);

  // R2 R5 R9
  load_to_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(ext_addr_i));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> ($stable(addr_o) || !$stable(order_sel_i)));

  // R7
  upper_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  // R4
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && !order_sel_i) |=>
      (order_sel_i || addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)));

  // R3
  ilv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && order_sel_i) |=>
      (!order_sel_i || addr_o[BEAT_W-1:0] != $past(addr_o[BEAT_W-1:0])));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ext_addr_i  (ext_addr_i),
  .load_i      (load_i),
  .adv_i       (adv_i),
  .order_sel_i (order_sel_i),
  .addr_o      (addr_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 17;
  localparam int NV = 21;
  localparam int VW = 3 + 2 * AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] ext_addr_i = '0;
  logic          load_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          order_sel_i = 1'b1;
  logic [AW-1:0] addr_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_addr_i(ext_addr_i),
    .load_i(load_i), .adv_i(adv_i), .order_sel_i(order_sel_i), .addr_o(addr_o)
  );

  // {load, adv, order, ext_addr, expected addr_o after the edge}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 17'h1A5C5, 17'h1A5C5},  // R2 R5 load ignores adv
    {1'b0, 1'b1, 1'b1, 17'h00000, 17'h1A5C4},  // R3 beat1
    {1'b0, 1'b0, 1'b1, 17'h00000, 17'h1A5C4},  // R6 hold
    {1'b0, 1'b1, 1'b1, 17'h00000, 17'h1A5C7},  // R3 beat2
    {1'b0, 1'b1, 1'b1, 17'h00000, 17'h1A5C6},  // R3 beat3
    {1'b0, 1'b1, 1'b1, 17'h00000, 17'h1A5C5},  // R8 wrap
    {1'b1, 1'b0, 1'b0, 17'h0F0F1, 17'h0F0F1},  // R2 linear load
    {1'b0, 1'b1, 1'b0, 17'h00000, 17'h0F0F2},  // R4
    {1'b0, 1'b1, 1'b0, 17'h00000, 17'h0F0F3},  // R4
    {1'b0, 1'b0, 1'b0, 17'h00000, 17'h0F0F3},  // R6
    {1'b0, 1'b1, 1'b0, 17'h00000, 17'h0F0F0},  // R4 R7
    {1'b0, 1'b1, 1'b0, 17'h00000, 17'h0F0F1},  // R8
    {1'b0, 1'b1, 1'b0, 17'h00000, 17'h0F0F2},  // R8 second loop
    {1'b1, 1'b1, 1'b0, 17'h12346, 17'h12346},  // R9 R5 reload mid burst
    {1'b0, 1'b1, 1'b0, 17'h00000, 17'h12347},  // R4
    {1'b0, 1'b1, 1'b0, 17'h00000, 17'h12344},  // R7 upper kept
    {1'b1, 1'b0, 1'b1, 17'h1FFFF, 17'h1FFFF},  // R2
    {1'b0, 1'b1, 1'b1, 17'h00000, 17'h1FFFE},  // R3
    {1'b0, 1'b1, 1'b1, 17'h00000, 17'h1FFFD},  // R3
    {1'b0, 1'b1, 1'b1, 17'h00000, 17'h1FFFC},  // R3 R7
    {1'b0, 1'b1, 1'b1, 17'h00000, 17'h1FFFF}   // R8
  };

  task automatic check(input string req, input logic [AW-1:0] exp);
    total++;
    if (addr_o !== exp) begin
      bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 in reset", '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", '0);

    for (int i = 0; i < NV; i++) begin
      load_i      = VEC[i][VW-1];
      adv_i       = VEC[i][VW-2];
      order_sel_i = VEC[i][VW-3];
      ext_addr_i  = VEC[i][2*AW-1:AW];
      @(negedge clk_i);
      check($sformatf("vec%0d R2-9", i), VEC[i][AW-1:0]);
    end

    // R5: load with adv on interleaved start 10, then held
    load_i = 1'b1; adv_i = 1'b1; order_sel_i = 1'b1; ext_addr_i = 17'h0AAAA;
    @(negedge clk_i);
    check("R5 load with adv", 17'h0AAAA);
    load_i = 1'b0; adv_i = 1'b0;
    @(negedge clk_i);
    check("R6 idle after load", 17'h0AAAA);
    adv_i = 1'b1;
    @(negedge clk_i);
    check("R3 start10 beat1", 17'h0AAAB);

    // R1: reset mid burst
    adv_i = 1'b0;
    rst_ni = 1'b0;
    #3;
    check("R1 async reset", '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 post reset hold", '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule